// File: doc/BRIEF.md
# Per-Function MSI Mask and Pending Register Bank

This block holds two 32-bit registers for each of up to eight physical functions: an interrupt mask word and a pending-status word. User logic replaces the pending word of one function by presenting the new word, the binary function number and a one-cycle write strobe together. A configuration-side write port replaces the mask word of one function. When that write changes the stored mask of a function whose MSI enable is set, the block emits a one-cycle change notification.

A select input chooses one function. The mask and pending words of that function appear on two registered read outputs one clock later. Upstream logic is expected to decode configuration space and generate messages. This block only stores the words, reports mask changes and reads them back.

Top module: `msi_mask_pend_bank`

## Requirements
- R1: When `pend_we` is high at a rising clock edge, the whole 32-bit pending word of the function numbered `pend_fn` (binary, value n selects function n, 0 to 7) is replaced by `pend_data`.
- R2: The pending word of a function is unchanged across any edge where `pend_we` is low, or where `pend_fn` names a different function.
- R3: When `mask_we` is high at a rising edge, the mask word of function `mask_fn` (binary, 0 to 7) takes `mask_data`. If that function's bit in `fn_enable` is 1 and the new word differs from the stored one, `mask_changed` is high for the following cycle.
- R4: `rd_mask` and `rd_pend` show the words of function `rd_sel` (binary, value n selects function n) as stored before the edge that samples `rd_sel`, and they are valid from that edge until the next one.
- R5: A mask write whose data equals the stored mask word produces no `mask_changed` pulse.
- R6: A mask write to a function whose `fn_enable` bit is 0 still stores the word but produces no `mask_changed` pulse.
- R7: While `rst_n` is low, every mask word, every pending word, `rd_mask`, `rd_pend` and `mask_changed` are zero.
- R8: A single changing mask write keeps `mask_changed` high for exactly one cycle. It is low in the cycle after the pulse unless another changing write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fn_enable | input | 8 | MSI enable bit for each function |
| pend_we | input | 1 | Pending word write strobe |
| pend_fn | input | 3 | Function whose pending word is written |
| pend_data | input | 32 | New pending word |
| mask_we | input | 1 | Mask word write strobe |
| mask_fn | input | 3 | Function whose mask word is written |
| mask_data | input | 32 | New mask word |
| rd_sel | input | 3 | Function chosen for read-back |
| rd_mask | output | 32 | Registered mask word of the selected function |
| rd_pend | output | 32 | Registered pending word of the selected function |
| mask_changed | output | 1 | One-cycle notification of an enabled mask change |

## Verification
The properties assume that the function numbers on `pend_fn`, `mask_fn` and `rd_sel` always name an existing function. They also assume that each write port carries at most one write per edge, with its strobe, number and data stable around the sampling edge. The stimulus changes inputs only on falling edges and uses only in-range function numbers. It covers every function on all three ports, with back-to-back writes separated by idle cycles so that each pulse can be seen alone.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  localparam int MSI_VEC_W  = 32;
  localparam int MSI_MAX_FN = 8;
  typedef logic [MSI_VEC_W-1:0] msi_word_t;
endpackage

// File: rtl/msi_fn_regs.sv
module msi_fn_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic         pend_wr,
  input  logic [W-1:0] pend_wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend_q,
  output logic         mask_diff
);
  logic [W-1:0] mask_d, pend_d;

  always_comb begin
    mask_d = mask_q;
    pend_d = pend_q;
    if (mask_wr) mask_d = mask_wdata;
    if (pend_wr) pend_d = pend_wdata;
  end

  // Raised only for a write that alters the stored word
  assign mask_diff = mask_wr && (mask_wdata != mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/msi_sel_read.sv
module msi_sel_read #(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int SW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SW-1:0]       sel,
  input  logic [N-1:0][W-1:0] mask_arr,
  input  logic [N-1:0][W-1:0] pend_arr,
  output logic [W-1:0]        rd_mask,
  output logic [W-1:0]        rd_pend
);
  logic [W-1:0] mask_d, pend_d;

  always_comb begin
    mask_d = '0;
    pend_d = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) begin
        mask_d = mask_arr[i];
        pend_d = pend_arr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mask <= '0;
      rd_pend <= '0;
    end else begin
      rd_mask <= mask_d;
      rd_pend <= pend_d;
    end
  end
endmodule

// File: rtl/msi_mask_pend_bank.sv
module msi_mask_pend_bank #(
  parameter int NUM_FN = msi_bank_pkg::MSI_MAX_FN,
  parameter int VEC_W  = msi_bank_pkg::MSI_VEC_W,
  parameter int FN_W   = $clog2(NUM_FN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FN-1:0] fn_enable,
  input  logic              pend_we,
  input  logic [FN_W-1:0]   pend_fn,
  input  logic [VEC_W-1:0]  pend_data,
  input  logic              mask_we,
  input  logic [FN_W-1:0]   mask_fn,
  input  logic [VEC_W-1:0]  mask_data,
  input  logic [FN_W-1:0]   rd_sel,
  output logic [VEC_W-1:0]  rd_mask,
  output logic [VEC_W-1:0]  rd_pend,
  output logic              mask_changed
);
  logic [NUM_FN-1:0][VEC_W-1:0] mask_arr;
  logic [NUM_FN-1:0][VEC_W-1:0] pend_arr;
  logic [NUM_FN-1:0]            diff_vec;
  logic                         changed_d;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    logic mask_hit, pend_hit;
    assign mask_hit = mask_we && (mask_fn == FN_W'(g));
    assign pend_hit = pend_we && (pend_fn == FN_W'(g));

    msi_fn_regs #(.W(VEC_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_wr    (mask_hit),
      .mask_wdata (mask_data),
      .pend_wr    (pend_hit),
      .pend_wdata (pend_data),
      .mask_q     (mask_arr[g]),
      .pend_q     (pend_arr[g]),
      .mask_diff  (diff_vec[g])
    );
  end

  assign changed_d = |(diff_vec & fn_enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_changed <= 1'b0;
    else        mask_changed <= changed_d;
  end

  msi_sel_read #(.N(NUM_FN), .W(VEC_W), .SW(FN_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (rd_sel),
    .mask_arr (mask_arr),
    .pend_arr (pend_arr),
    .rd_mask  (rd_mask),
    .rd_pend  (rd_pend)
  );
endmodule

// File: rtl/msi_bank_chk.sv
module msi_bank_chk #(
  parameter int NUM_FN = 8,
  parameter int VEC_W  = 32,
  parameter int FN_W   = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_FN-1:0]            fn_enable,
  input logic                         pend_we,
  input logic [FN_W-1:0]              pend_fn,
  input logic [VEC_W-1:0]             pend_data,
  input logic                         mask_we,
  input logic [FN_W-1:0]              mask_fn,
  input logic [VEC_W-1:0]             mask_data,
  input logic [FN_W-1:0]              rd_sel,
  input logic [VEC_W-1:0]             rd_mask,
  input logic [VEC_W-1:0]             rd_pend,
  input logic                         mask_changed,
  input logic [NUM_FN-1:0][VEC_W-1:0] mask_arr,
  input logic [NUM_FN-1:0][VEC_W-1:0] pend_arr
);
  a_r1_pend_write: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> pend_arr[$past(pend_fn)] == $past(pend_data));

  a_r2_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_we |=> $stable(pend_arr));

  a_r3_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_we) |-> !mask_changed);

  a_r4_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_mask == $past(mask_arr[rd_sel]));

  a_r4_read_pend: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_pend == $past(pend_arr[rd_sel]));

  a_r5_equal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_data == mask_arr[mask_fn]) |=> !mask_changed);

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !fn_enable[mask_fn]) |=> !mask_changed);

  a_r6_disabled_store: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_arr[$past(mask_fn)] == $past(mask_data));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_changed && !mask_we) |=> !mask_changed);
endmodule

bind msi_mask_pend_bank msi_bank_chk #(
  .NUM_FN (NUM_FN),
  .VEC_W  (VEC_W),
  .FN_W   (FN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fn_enable    (fn_enable),
  .pend_we      (pend_we),
  .pend_fn      (pend_fn),
  .pend_data    (pend_data),
  .mask_we      (mask_we),
  .mask_fn      (mask_fn),
  .mask_data    (mask_data),
  .rd_sel       (rd_sel),
  .rd_mask      (rd_mask),
  .rd_pend      (rd_pend),
  .mask_changed (mask_changed),
  .mask_arr     (mask_arr),
  .pend_arr     (pend_arr)
);

// File: tb/tb_msi_mask_pend_bank.sv
`timescale 1ns/1ps
module tb_msi_mask_pend_bank;
  localparam int N = 8;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] fn_enable;
  logic         pend_we, mask_we;
  logic [2:0]   pend_fn, mask_fn, rd_sel;
  logic [W-1:0] pend_data, mask_data, rd_mask, rd_pend;
  logic         mask_changed;

  logic [W-1:0] ref_mask [N];
  logic [W-1:0] ref_pend [N];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  msi_mask_pend_bank dut (
    .clk(clk), .rst_n(rst_n), .fn_enable(fn_enable),
    .pend_we(pend_we), .pend_fn(pend_fn), .pend_data(pend_data),
    .mask_we(mask_we), .mask_fn(mask_fn), .mask_data(mask_data),
    .rd_sel(rd_sel), .rd_mask(rd_mask), .rd_pend(rd_pend),
    .mask_changed(mask_changed)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read back one function and compare both words with the model (R4)
  task automatic read_fn(input int f, input string req);
    @(negedge clk);
    rd_sel = 3'(f);
    @(negedge clk);
    check({req, " R4 mask"}, rd_mask, ref_mask[f]);
    check({req, " R4 pend"}, rd_pend, ref_pend[f]);
  endtask

  task automatic write_pend(input int f, input logic [W-1:0] d);
    @(negedge clk);
    pend_we = 1'b1; pend_fn = 3'(f); pend_data = d;
    @(negedge clk);
    pend_we = 1'b0;
    ref_pend[f] = d;
  endtask

  // Mask write; pulse expected in the cycle after the write edge, gone one cycle later
  task automatic write_mask(input int f, input logic [W-1:0] d, input string req);
    logic exp_pulse;
    @(negedge clk);
    exp_pulse = fn_enable[f] && (d != ref_mask[f]);
    mask_we = 1'b1; mask_fn = 3'(f); mask_data = d;
    @(negedge clk);
    mask_we = 1'b0;
    ref_mask[f] = d;
    check({req, " pulse"}, W'(mask_changed), W'(exp_pulse));
    @(negedge clk);
    check("R8 pulse width", W'(mask_changed), '0);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fn_enable = '0; pend_we = 0; mask_we = 0;
    pend_fn = 0; mask_fn = 0; rd_sel = 0; pend_data = '0; mask_data = '0;
    for (int i = 0; i < N; i++) begin ref_mask[i] = '0; ref_pend[i] = '0; end
    repeat (3) @(negedge clk);
    check("R7 rd_mask", rd_mask, '0);
    check("R7 rd_pend", rd_pend, '0);
    check("R7 pulse", W'(mask_changed), '0);
    rst_n = 1'b1;
    for (int f = 0; f < N; f++) read_fn(f, "R7 after reset");

    // Pending writes to every function (R1)
    for (int f = 0; f < N; f++) write_pend(f, 32'hA5000000 ^ (32'(f) * 32'h01010101));
    for (int f = 0; f < N; f++) read_fn(f, "R1");

    // Pending data toggles with strobe low: nothing moves (R2)
    @(negedge clk);
    pend_fn = 3'd3; pend_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    for (int f = 0; f < N; f++) read_fn(f, "R2 strobe low");
    write_pend(5, 32'h0000_0001);
    for (int f = 0; f < N; f++) read_fn(f, "R2 other fn");

    // Mask writes with alternating enables (R3 / R6)
    fn_enable = 8'b0101_0101;
    for (int f = 0; f < N; f++)
      write_mask(f, 32'h1 << (f * 3), fn_enable[f] ? "R3 enabled" : "R6 disabled");
    for (int f = 0; f < N; f++) read_fn(f, "R3 R6 stored");

    // Equal rewrite on enabled function (R5)
    write_mask(2, ref_mask[2], "R5 equal");
    fn_enable = 8'hFF;
    write_mask(1, ref_mask[1], "R5 equal enabled");
    write_mask(1, 32'hDEAD_BEEF, "R3 change");
    write_mask(7, 32'h0, "R3 clear");
    fn_enable = 8'h00;
    write_mask(6, 32'h1234_5678, "R6 all disabled");
    for (int f = 0; f < N; f++) read_fn(f, "R4 final");

    // Reset again clears everything (R7)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin ref_mask[i] = '0; ref_pend[i] = '0; end
    for (int f = 0; f < N; f++) read_fn(f, "R7 second reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule